// File: doc/BRIEF.md
# Low-Power Mode Controller

This block steps a small processor subsystem through four power modes: Active, Idle, Standby and Shutdown. Software first writes the wanted mode into a mode register. The mode takes effect on the next sleep strobe from the CPU. From then on the block drives one enable per power or clock domain.

Each mode has its own wake sources:
- Idle returns to Active on any interrupt.
- Standby resumes on an RTC event or on a wake-pin edge. The resume is staged: the high-speed clock comes back first, the CPU clock follows its ready acknowledge, and the I/O latch opens last.
- Shutdown turns off every domain and keeps only the I/O latch. A wake-pin edge restarts the device through a reset, and a one-hot register records that cause.

The reset pin and power-on reset override everything. Wake pins pass through a synchronizer and are compared only on ticks of the low-speed clock.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: Power-on reset turns every domain output off and sets the cause register to one-hot 3'b001 (bit 0). One clock edge after `por_i` falls, the Active set is driven. Only power-on reset clears the cause register.
- R2: Mode codes are 0 Active, 1 Idle, 2 Standby and 3 Shutdown. A sleep strobe with code 0 or an invalid code (4 to 7) keeps the Active set. The domain vector is {cpu, flash, sram_pwr, sram_ret, radio, periph, hf, lf, brownout_en, brownout_duty, por_mon, wdt_pause, io_latch, aon}, and Active drives 14'b11101111101001.
- R3: A sleep strobe with code 1 enters Idle, 14'b00101111101001, on the next edge. In Idle only `irq_i` wakes the block, giving Active on the next edge. An RTC event has no effect in Idle.
- R4: A sleep strobe with code 2 enters Standby, 14'b00110001111111. An interrupt has no effect in Standby.
- R5: An RTC event or an enabled wake-pin edge in Standby leads to 14'b00110011111111, in which only the high-speed clock has come back. This set holds until `hf_rdy_i` is seen. Next comes one cycle of 14'b11100011101011, with the CPU clock on and the I/O still latched. Then Active follows. The cause register is not changed.
- R6: A sleep strobe with code 3 enters Shutdown, 14'b00000000000010. An RTC event or an interrupt has no effect in Shutdown.
- R7: In Shutdown, a level change on a wake pin whose `wake_en_i` bit is 1 causes one cycle of all-off. During that cycle the cause register becomes 3'b100 (bit 2). Active follows, with the mode register back to code 0. A pin whose enable bit is 0 has no effect.
- R8: While `rst_pin_i` is high, in any mode, every domain output is 0 from the next edge on and the cause register is 3'b010 (bit 1). Active follows one edge after release.
- R9: Wake pins pass through two synchronizing flops and are compared only on edges where `lf_tick_i` is high. A pin change made while the tick is low produces no wake. The first tick edge detects it, and the mode reacts on the edge after that.
- R10: A mode register write without a sleep strobe leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| rst_pin_i | input | 1 | External reset pin level, active high |
| mode_wr_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | MODE_W | Mode code to store |
| sleep_i | input | 1 | CPU sleep strobe |
| irq_i | input | 1 | Any interrupt pending |
| rtc_evt_i | input | 1 | RTC event |
| wake_pin_i | input | NUM_PINS | Raw wake pin levels |
| wake_en_i | input | NUM_PINS | Per-pin wake enable |
| lf_tick_i | input | 1 | Low-speed clock sample tick |
| hf_rdy_i | input | 1 | High-speed clock ready acknowledge |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| flash_pwr_o | output | 1 | Flash power |
| sram_pwr_o | output | 1 | SRAM power |
| sram_ret_o | output | 1 | SRAM retention mode |
| radio_en_o | output | 1 | Radio allowed |
| periph_en_o | output | 1 | Peripheral domain enable |
| hf_clk_en_o | output | 1 | High-speed clock enable |
| lf_clk_en_o | output | 1 | Low-speed clock enable |
| brownout_en_o | output | 1 | Brownout detector enable |
| brownout_duty_o | output | 1 | Brownout detector duty-cycled |
| por_mon_o | output | 1 | Power-on reset monitor active |
| wdt_pause_o | output | 1 | Watchdog paused |
| io_latch_o | output | 1 | I/O state latched |
| aon_en_o | output | 1 | Always-on domain powered |
| rst_cause_o | output | 3 | One-hot last reset cause |

## Verification
The bench targets the staged Standby resume:
- A design that opened the CPU clock before `hf_rdy_i`, or released the I/O latch together with the CPU clock, would show a wrong domain vector in the cycles after the wake.

It also targets sources that must be ignored:
- an RTC event in Idle or Shutdown;
- an interrupt in Standby;
- a toggle on a disabled pin;
- a pin change while the sample tick is low.

Each of these would show up as an early wake. A Shutdown wake that resumed instead of resetting would skip the all-off cycle, leave the cause at its old value and keep the old mode code.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    ST_RST, ST_ACT, ST_IDLE, ST_STBY, ST_WKHF, ST_WKCPU, ST_SHDN
  } pm_state_e;

  typedef struct packed {
    logic cpu;
    logic flash;
    logic sram;
    logic ret;
    logic radio;
    logic periph;
    logic hf;
    logic lf;
    logic bo_en;
    logic bo_duty;
    logic por_mon;
    logic wdt_pause;
    logic io_latch;
    logic aon;
  } pm_dom_t;

  localparam int DOM_W = $bits(pm_dom_t);

  function automatic pm_dom_t dom_of(pm_state_e s);
    pm_dom_t d;
    case (s)
      ST_ACT:   d = pm_dom_t'(14'b11101111101001);
      ST_IDLE:  d = pm_dom_t'(14'b00101111101001);
      ST_STBY:  d = pm_dom_t'(14'b00110001111111);
      ST_WKHF:  d = pm_dom_t'(14'b00110011111111);
      ST_WKCPU: d = pm_dom_t'(14'b11100011101011);
      ST_SHDN:  d = pm_dom_t'(14'b00000000000010);
      default:  d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/pwr_wake_sync.sv
module pwr_wake_sync #(
  parameter int NUM_PINS = 2,
  parameter int STAGES   = 2
) (
  input  logic                clk,
  input  logic                por_i,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] pin_en_i,
  input  logic                tick_i,
  output logic                evt_o
);
  logic [NUM_PINS-1:0] stg_q [STAGES];
  logic [NUM_PINS-1:0] last_q;
  logic                evt_q;

  always_ff @(posedge clk) begin
    if (por_i) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      last_q <= '0;
      evt_q  <= 1'b0;
    end else begin
      stg_q[0] <= pin_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      if (tick_i) begin
        last_q <= stg_q[STAGES-1];
        evt_q  <= |((stg_q[STAGES-1] ^ last_q) & pin_en_i);
      end else begin
        evt_q  <= 1'b0;
      end
    end
  end

  assign evt_o = evt_q;
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
#(
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              por_i,
  input  logic              rst_pin_i,
  input  logic              mode_wr_i,
  input  logic [MODE_W-1:0] mode_wdata_i,
  input  logic              sleep_i,
  input  logic              irq_i,
  input  logic              rtc_evt_i,
  input  logic              wake_evt_i,
  input  logic              hf_rdy_i,
  output pm_state_e         state_nxt_o,
  output logic              shdn_wake_o
);
  localparam logic [MODE_W-1:0] CODE_IDLE = MODE_W'(1);
  localparam logic [MODE_W-1:0] CODE_STBY = MODE_W'(2);
  localparam logic [MODE_W-1:0] CODE_SHDN = MODE_W'(3);

  pm_state_e         state_q, nxt;
  logic [MODE_W-1:0] mode_q;
  logic              swake;

  always_comb begin
    nxt   = state_q;
    swake = 1'b0;
    case (state_q)
      ST_RST:   nxt = ST_ACT;
      ST_ACT: begin
        if (sleep_i) begin
          if (mode_q == CODE_IDLE)      nxt = ST_IDLE;
          else if (mode_q == CODE_STBY) nxt = ST_STBY;
          else if (mode_q == CODE_SHDN) nxt = ST_SHDN;
        end
      end
      ST_IDLE:  if (irq_i) nxt = ST_ACT;
      ST_STBY:  if (rtc_evt_i || wake_evt_i) nxt = ST_WKHF;
      ST_WKHF:  if (hf_rdy_i) nxt = ST_WKCPU;
      ST_WKCPU: nxt = ST_ACT;
      ST_SHDN: begin
        if (wake_evt_i) begin
          nxt   = ST_RST;
          swake = 1'b1;
        end
      end
      default:  nxt = ST_RST;
    endcase
    if (rst_pin_i) begin
      nxt   = ST_RST;
      swake = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (por_i) begin
      state_q <= ST_RST;
      mode_q  <= '0;
    end else begin
      state_q <= nxt;
      if (nxt == ST_RST)  mode_q <= '0;
      else if (mode_wr_i) mode_q <= mode_wdata_i;
    end
  end

  assign state_nxt_o = nxt;
  assign shdn_wake_o = swake;
endmodule

// File: rtl/pwr_dom_map.sv
module pwr_dom_map
  import pwr_mode_pkg::*;
(
  input  logic      clk,
  input  logic      por_i,
  input  pm_state_e state_nxt_i,
  output pm_dom_t   dom_o
);
  pm_dom_t dom_q;

  always_ff @(posedge clk) begin
    if (por_i) dom_q <= '0;
    else       dom_q <= dom_of(state_nxt_i);
  end

  assign dom_o = dom_q;
endmodule

// File: rtl/pwr_rst_cause.sv
module pwr_rst_cause (
  input  logic       clk,
  input  logic       por_i,
  input  logic       rst_pin_i,
  input  logic       shdn_wake_i,
  output logic [2:0] cause_o
);
  logic [2:0] cause_q;

  always_ff @(posedge clk) begin
    if (por_i)            cause_q <= 3'b001;
    else if (rst_pin_i)   cause_q <= 3'b010;
    else if (shdn_wake_i) cause_q <= 3'b100;
  end

  assign cause_o = cause_q;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int NUM_PINS    = 2,
  parameter int MODE_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                por_i,
  input  logic                rst_pin_i,
  input  logic                mode_wr_i,
  input  logic [MODE_W-1:0]   mode_wdata_i,
  input  logic                sleep_i,
  input  logic                irq_i,
  input  logic                rtc_evt_i,
  input  logic [NUM_PINS-1:0] wake_pin_i,
  input  logic [NUM_PINS-1:0] wake_en_i,
  input  logic                lf_tick_i,
  input  logic                hf_rdy_i,
  output logic                cpu_clk_en_o,
  output logic                flash_pwr_o,
  output logic                sram_pwr_o,
  output logic                sram_ret_o,
  output logic                radio_en_o,
  output logic                periph_en_o,
  output logic                hf_clk_en_o,
  output logic                lf_clk_en_o,
  output logic                brownout_en_o,
  output logic                brownout_duty_o,
  output logic                por_mon_o,
  output logic                wdt_pause_o,
  output logic                io_latch_o,
  output logic                aon_en_o,
  output logic [2:0]          rst_cause_o
);
  logic      wake_evt, shdn_wake;
  pm_state_e state_nxt;
  pm_dom_t   dom;

  pwr_wake_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .por_i(por_i), .pin_i(wake_pin_i), .pin_en_i(wake_en_i),
    .tick_i(lf_tick_i), .evt_o(wake_evt)
  );

  pwr_mode_fsm #(.MODE_W(MODE_W)) u_fsm (
    .clk(clk), .por_i(por_i), .rst_pin_i(rst_pin_i), .mode_wr_i(mode_wr_i),
    .mode_wdata_i(mode_wdata_i), .sleep_i(sleep_i), .irq_i(irq_i),
    .rtc_evt_i(rtc_evt_i), .wake_evt_i(wake_evt), .hf_rdy_i(hf_rdy_i),
    .state_nxt_o(state_nxt), .shdn_wake_o(shdn_wake)
  );

  pwr_dom_map u_map (
    .clk(clk), .por_i(por_i), .state_nxt_i(state_nxt), .dom_o(dom)
  );

  pwr_rst_cause u_cause (
    .clk(clk), .por_i(por_i), .rst_pin_i(rst_pin_i),
    .shdn_wake_i(shdn_wake), .cause_o(rst_cause_o)
  );

  assign cpu_clk_en_o    = dom.cpu;
  assign flash_pwr_o     = dom.flash;
  assign sram_pwr_o      = dom.sram;
  assign sram_ret_o      = dom.ret;
  assign radio_en_o      = dom.radio;
  assign periph_en_o     = dom.periph;
  assign hf_clk_en_o     = dom.hf;
  assign lf_clk_en_o     = dom.lf;
  assign brownout_en_o   = dom.bo_en;
  assign brownout_duty_o = dom.bo_duty;
  assign por_mon_o       = dom.por_mon;
  assign wdt_pause_o     = dom.wdt_pause;
  assign io_latch_o      = dom.io_latch;
  assign aon_en_o        = dom.aon;
endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk (
  input logic       clk,
  input logic       por_i,
  input logic       rst_pin_i,
  input logic       irq_i,
  input logic       rtc_evt_i,
  input logic       cpu_clk_en_o,
  input logic       flash_pwr_o,
  input logic       sram_pwr_o,
  input logic       periph_en_o,
  input logic       hf_clk_en_o,
  input logic       lf_clk_en_o,
  input logic       wdt_pause_o,
  input logic       io_latch_o,
  input logic       aon_en_o,
  input logic [2:0] rst_cause_o
);
  // R8
  rst_pin_off_chk: assert property (@(posedge clk) disable iff (por_i)
    rst_pin_i |=> !cpu_clk_en_o && !flash_pwr_o && !sram_pwr_o && !lf_clk_en_o && !aon_en_o && !io_latch_o);

  // R1
  cause_onehot_chk: assert property (@(posedge clk) disable iff (por_i)
    $countones(rst_cause_o) == 1);

  // R5
  cpu_after_hf_chk: assert property (@(posedge clk) disable iff (por_i)
    ($rose(cpu_clk_en_o) && io_latch_o) |-> $past(hf_clk_en_o));

  // R5
  latch_release_chk: assert property (@(posedge clk) disable iff (por_i)
    ($fell(io_latch_o) && aon_en_o) |-> $past(cpu_clk_en_o));

  // R4
  stby_no_jump_chk: assert property (@(posedge clk) disable iff (por_i)
    (wdt_pause_o && !hf_clk_en_o) |=> !cpu_clk_en_o);

  // R3
  idle_irq_wake_chk: assert property (@(posedge clk) disable iff (por_i)
    (!cpu_clk_en_o && periph_en_o && irq_i && !rst_pin_i) |=> cpu_clk_en_o);

  // R6
  shdn_rtc_ignore_chk: assert property (@(posedge clk) disable iff (por_i)
    (io_latch_o && !aon_en_o && rtc_evt_i) |=> !cpu_clk_en_o);
endmodule

bind pwr_mode_ctrl pwr_mode_chk u_chk (.*);

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;
  localparam logic [13:0] D_ACT  = 14'b11101111101001;
  localparam logic [13:0] D_IDLE = 14'b00101111101001;
  localparam logic [13:0] D_STBY = 14'b00110001111111;
  localparam logic [13:0] D_WKHF = 14'b00110011111111;
  localparam logic [13:0] D_WKCP = 14'b11100011101011;
  localparam logic [13:0] D_SHDN = 14'b00000000000010;
  localparam logic [13:0] D_OFF  = 14'b0;
  localparam int NV = 22;

  // {req[3:0], wr, wdata[2:0], sleep, irq, rtc, rdy, expected[13:0]}
  localparam logic [25:0] VEC [NV] = '{
    {4'd2,  1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, D_ACT },  // R2 idle cycle
    {4'd10, 1'b1, 3'd5, 1'b0, 1'b0, 1'b0, 1'b1, D_ACT },  // R10 write only
    {4'd2,  1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, D_ACT },  // R2 invalid code
    {4'd10, 1'b1, 3'd1, 1'b0, 1'b0, 1'b0, 1'b1, D_ACT },  // R10
    {4'd3,  1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, D_IDLE},  // R3 enter
    {4'd3,  1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, D_IDLE},  // R3 rtc ignored
    {4'd3,  1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1, D_ACT },  // R3 irq wake
    {4'd10, 1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 1'b1, D_ACT },  // R10
    {4'd4,  1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, D_STBY},  // R4 enter
    {4'd4,  1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1, D_STBY},  // R4 irq ignored
    {4'd5,  1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, D_WKHF},  // R5 rtc wake
    {4'd5,  1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, D_WKHF},  // R5 wait ready
    {4'd5,  1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, D_WKCP},  // R5 cpu on
    {4'd5,  1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, D_ACT },  // R5 latch off
    {4'd4,  1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, D_STBY},  // R4 re-enter
    {4'd5,  1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, D_WKHF},  // R5
    {4'd5,  1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, D_WKCP},  // R5
    {4'd5,  1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, D_ACT },  // R5
    {4'd10, 1'b1, 3'd3, 1'b0, 1'b0, 1'b0, 1'b1, D_ACT },  // R10
    {4'd6,  1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, D_SHDN},  // R6 enter
    {4'd6,  1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, D_SHDN},  // R6 rtc ignored
    {4'd6,  1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1, D_SHDN}   // R6 irq ignored
  };

  logic clk = 1'b0;
  logic por_i = 1'b1, rst_pin_i = 1'b0, mode_wr_i = 1'b0, sleep_i = 1'b0;
  logic irq_i = 1'b0, rtc_evt_i = 1'b0, lf_tick_i = 1'b1, hf_rdy_i = 1'b1;
  logic [2:0] mode_wdata_i = '0;
  logic [1:0] wake_pin_i = '0, wake_en_i = 2'b01;
  logic cpu, flash, sram, ret, radio, periph, hf, lf, bo_en, bo_duty, pmon, wdtp, latch, aon;
  logic [2:0] cause;
  logic [13:0] dom;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl u0 (
    .clk(clk), .por_i(por_i), .rst_pin_i(rst_pin_i), .mode_wr_i(mode_wr_i),
    .mode_wdata_i(mode_wdata_i), .sleep_i(sleep_i), .irq_i(irq_i),
    .rtc_evt_i(rtc_evt_i), .wake_pin_i(wake_pin_i), .wake_en_i(wake_en_i),
    .lf_tick_i(lf_tick_i), .hf_rdy_i(hf_rdy_i),
    .cpu_clk_en_o(cpu), .flash_pwr_o(flash), .sram_pwr_o(sram), .sram_ret_o(ret),
    .radio_en_o(radio), .periph_en_o(periph), .hf_clk_en_o(hf), .lf_clk_en_o(lf),
    .brownout_en_o(bo_en), .brownout_duty_o(bo_duty), .por_mon_o(pmon),
    .wdt_pause_o(wdtp), .io_latch_o(latch), .aon_en_o(aon), .rst_cause_o(cause)
  );

  assign dom = {cpu, flash, sram, ret, radio, periph, hf, lf, bo_en, bo_duty, pmon, wdtp, latch, aon};

  task automatic chk(string tag, logic [13:0] act, logic [13:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    step(3);
    chk("R1 domains off in reset", dom, D_OFF);
    chk("R1 cause after power-on", {11'b0, cause}, 14'd1);
    por_i = 1'b0;
    step(1);
    chk("R1 active after release", dom, D_ACT);

    for (int i = 0; i < NV; i++) begin
      mode_wr_i    = VEC[i][21];
      mode_wdata_i = VEC[i][20:18];
      sleep_i      = VEC[i][17];
      irq_i        = VEC[i][16];
      rtc_evt_i    = VEC[i][15];
      hf_rdy_i     = VEC[i][14];
      step(1);
      chk($sformatf("R%0d vector %0d", VEC[i][25:22], i), dom, VEC[i][13:0]);
    end
    {mode_wr_i, sleep_i, irq_i, rtc_evt_i} = '0;
    hf_rdy_i = 1'b1;

    // R7: disabled pin toggles, no effect in Shutdown
    wake_pin_i[1] = 1'b1;
    step(8);
    chk("R7 disabled pin ignored", dom, D_SHDN);

    // R9: tick held low, enabled pin change must not wake
    lf_tick_i = 1'b0;
    wake_pin_i[0] = 1'b1;
    step(8);
    chk("R9 no wake without tick", dom, D_SHDN);
    lf_tick_i = 1'b1;
    step(1);
    chk("R9 detect cycle only", dom, D_SHDN);
    step(1);
    chk("R7 reset cycle all off", dom, D_OFF);
    chk("R7 cause wake pin", {11'b0, cause}, 14'd4);
    step(1);
    chk("R7 active after wake reset", dom, D_ACT);
    sleep_i = 1'b1;
    step(1);
    sleep_i = 1'b0;
    chk("R7 mode code cleared", dom, D_ACT);

    // R8: reset pin from Idle
    mode_wr_i = 1'b1; mode_wdata_i = 3'd1;
    step(1);
    mode_wr_i = 1'b0; sleep_i = 1'b1;
    step(1);
    sleep_i = 1'b0;
    chk("R8 precondition idle", dom, D_IDLE);
    rst_pin_i = 1'b1;
    step(3);
    chk("R8 off while held", dom, D_OFF);
    chk("R8 cause reset pin", {11'b0, cause}, 14'd2);
    rst_pin_i = 1'b0;
    step(1);
    chk("R8 active after release", dom, D_ACT);

    // R5: Standby woken by falling edge on enabled pin
    mode_wr_i = 1'b1; mode_wdata_i = 3'd2;
    step(1);
    mode_wr_i = 1'b0; sleep_i = 1'b1;
    step(1);
    sleep_i = 1'b0;
    chk("R5 standby entered", dom, D_STBY);
    wake_pin_i[0] = 1'b0;
    step(10);
    chk("R5 pin wake resumes", dom, D_ACT);
    chk("R5 cause unchanged", {11'b0, cause}, 14'd2);

    // R1: power-on again clears cause
    por_i = 1'b1;
    step(2);
    por_i = 1'b0;
    chk("R1 cause cleared by power-on", {11'b0, cause}, 14'd1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule